// File: doc/BRIEF.md
# Trigger event ID serializer

This block assembles an identity record for every Level-1 accept and ships it to the readout boards over one serial wire. A record holds a 24-bit trigger number, a 12-bit bunch-crossing number, an 8-bit trigger type and 2 spare bits, 46 bits in all. Accepts can arrive much faster than one record can be shifted out, so captured records wait in a 16-entry queue. A shifter drains the queue one frame at a time.

Stand-alone operation uses two local counters. The trigger counter advances once per accept and is cleared by an event-counter-reset command. The bunch counter advances every clock, wraps at a programmable maximum and is cleared by a bunch-counter-reset command. In run mode the trigger and bunch numbers are taken from an external timing receiver instead. The trigger type and the spare bits always come from their input pins.

Top module: `evid_link`

## Requirements
- R1: After reset `ser_out` is low, `fifo_empty` is 1, `fifo_full` is 0, `fifo_level` is 0 and `overflow` is 0.
- R2: A frame is one high start bit, then 46 record bits sent MSB first, then one low stop bit. Record bits [45:22] are the trigger number, [21:10] the bunch number, [9:2] the trigger type and [1:0] the spare bits. `ser_out` stays low whenever no frame is being sent.
- R3: When an accept is sampled on a clock edge and the queue was empty and the shifter idle, the start bit appears on the output after the second following edge.
- R4: In stand-alone mode a record carries the trigger count as it stood before its own accept. The first accept after reset carries 0. Every accept advances the counter by one, including an accept that is dropped.
- R5: `ecr` clears the trigger counter. An accept in the same cycle as `ecr` carries trigger number 0, and the next accept carries 1.
- R6: The bunch counter increments on every clock and goes to 0 after reaching `bc_max`. When `bcr` is sampled on an edge, the counter reads 0 after that edge. A record carries the counter value current in its accept cycle, so an accept k cycles after `bcr` carries (k-1) mod (`bc_max`+1).
- R7: With `run_mode` high, the record takes its trigger and bunch numbers from `ext_trig` and `ext_bunch`.
- R8: Records leave in accept order. Back-to-back accepts are all queued. `fifo_level` counts the records waiting, not counting the one being shifted. `fifo_empty` and `fifo_full` follow `fifo_level`.
- R9: An accept that finds the queue full (16 records) is dropped and sets `overflow`. `overflow` then stays set until reset.
- R10: While records are waiting, frames follow each other with no gap: their start bits are exactly 48 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 1: trigger and bunch numbers come from the external receiver |
| l1a | input | 1 | Level-1 accept, one cycle per trigger |
| ecr | input | 1 | Event-counter reset command |
| bcr | input | 1 | Bunch-counter reset command |
| bc_max | input | 12 | Last value of the bunch counter before it wraps |
| ext_trig | input | 24 | External trigger number (run mode) |
| ext_bunch | input | 12 | External bunch number (run mode) |
| trig_type | input | 8 | Trigger type captured with each accept |
| spare | input | 2 | Spare bits captured with each accept |
| ser_out | output | 1 | Serial record output, idles low |
| fifo_empty | output | 1 | No record waiting |
| fifo_full | output | 1 | 16 records waiting |
| fifo_level | output | 5 | Number of records waiting |
| overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
Several functions can act in the same cycle. An accept can arrive together with an event-counter reset, which both clears the counter and sets the value captured. The bench drives `ecr` and `l1a` in the same cycle and expects trigger numbers 0 and then 1 in the next two frames. An accept can also come in the same cycle that the shifter pops the queue. A burst of back-to-back accepts arrives while the first frame is still going out. The bench expects the queue to fill after the seventeenth accept and the eighteenth to be dropped and set the sticky flag. It then decodes all seventeen queued frames in order and checks that they are exactly 48 cycles apart.

// File: rtl/evid_pkg.sv
package evid_pkg;
  localparam int TRIG_W  = 24;
  localparam int BUNCH_W = 12;
  localparam int TYPE_W  = 8;
  localparam int SPARE_W = 2;

  typedef struct packed {
    logic [TRIG_W-1:0]  trig;
    logic [BUNCH_W-1:0] bunch;
    logic [TYPE_W-1:0]  ttype;
    logic [SPARE_W-1:0] spare;
  } evid_rec_t;

  localparam int REC_W = $bits(evid_rec_t);
endpackage

// File: rtl/evid_rst_sync.sv
module evid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  // asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/evid_counters.sv
module evid_counters #(
  parameter int TW = 24,
  parameter int BW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l1a,
  input  logic          ecr,
  input  logic          bcr,
  input  logic [BW-1:0] bc_max,
  output logic [TW-1:0] trig_now,
  output logic [BW-1:0] bunch_now
);
  logic [TW-1:0] trig_q, trig_nxt;
  logic [BW-1:0] bunch_q, bunch_nxt;
  logic          trig_en;

  always_comb begin
    trig_en = l1a | ecr;
    if (ecr)      trig_nxt = l1a ? TW'(1) : '0;
    else          trig_nxt = trig_q + TW'(1);
    if (bcr)                    bunch_nxt = '0;
    else if (bunch_q == bc_max) bunch_nxt = '0;
    else                        bunch_nxt = bunch_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      bunch_q <= '0;
    end else begin
      if (trig_en) trig_q <= trig_nxt;
      bunch_q <= bunch_nxt;
    end
  end

  // value seen by an accept in this cycle: reset command wins
  assign trig_now  = ecr ? '0 : trig_q;
  assign bunch_now = bunch_q;

  AST_TRIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && !ecr) |=> (trig_q == TW'($past(trig_q) + 1'b1))); // R4
  AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ecr |=> (trig_q == ($past(l1a) ? TW'(1) : TW'(0)))); // R5
  AST_BUNCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bcr || bunch_q == bc_max) |=> (bunch_q == '0)); // R6
endmodule

// File: rtl/evid_fifo.sv
module evid_fifo #(
  parameter int W     = 46,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_nxt, rd_q, rd_nxt;
  logic [LW-1:0] lvl_q, lvl_nxt;

  always_comb begin
    wr_nxt  = push ? wr_q + AW'(1) : wr_q;
    rd_nxt  = pop  ? rd_q + AW'(1) : rd_q;
    lvl_nxt = lvl_q;
    if (push && !pop)      lvl_nxt = lvl_q + LW'(1);
    else if (pop && !push) lvl_nxt = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  // storage has no reset; only the write enable gates it
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LW'(DEPTH));
  assign level = lvl_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level == LW'($past(level) + 1'b1))); // R8
endmodule

// File: rtl/evid_serializer.sv
module evid_serializer #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rec_valid,
  input  logic [W-1:0] rec,
  output logic         pop,
  output logic         ser_out
);
  localparam int FW = W + 2;
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sh_q, sh_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          busy_q, busy_nxt;
  logic          last, load;

  always_comb begin
    last     = busy_q && (cnt_q == '0);
    load     = rec_valid && (!busy_q || last);
    sh_nxt   = sh_q;
    cnt_nxt  = cnt_q;
    busy_nxt = busy_q;
    if (load) begin
      sh_nxt   = {1'b1, rec, 1'b0};
      cnt_nxt  = CW'(FW - 1);
      busy_nxt = 1'b1;
    end else if (last) begin
      busy_nxt = 1'b0;
    end else if (busy_q) begin
      sh_nxt  = {sh_q[FW-2:0], 1'b0};
      cnt_nxt = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_nxt;
      cnt_q  <= cnt_nxt;
      busy_q <= busy_nxt;
    end
  end

  assign pop     = load;
  assign ser_out = busy_q & sh_q[FW-1];

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ser_out); // R3
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == CW'($past(cnt_q) - 1'b1))); // R10
endmodule

// File: rtl/evid_link.sv
module evid_link
  import evid_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run_mode,
  input  logic                        l1a,
  input  logic                        ecr,
  input  logic                        bcr,
  input  logic [BUNCH_W-1:0]          bc_max,
  input  logic [TRIG_W-1:0]           ext_trig,
  input  logic [BUNCH_W-1:0]          ext_bunch,
  input  logic [TYPE_W-1:0]           trig_type,
  input  logic [SPARE_W-1:0]          spare,
  output logic                        ser_out,
  output logic                        fifo_empty,
  output logic                        fifo_full,
  output logic [$clog2(FIFO_DEPTH):0] fifo_level,
  output logic                        overflow
);
  logic              rst_ns;
  logic [TRIG_W-1:0]  loc_trig;
  logic [BUNCH_W-1:0] loc_bunch;
  evid_rec_t         cap_rec;
  logic [REC_W-1:0]  head;
  logic              push, pop;
  logic              ovf_q, ovf_nxt, ovf_en;

  evid_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  evid_counters #(.TW(TRIG_W), .BW(BUNCH_W)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .l1a(l1a), .ecr(ecr), .bcr(bcr),
    .bc_max(bc_max), .trig_now(loc_trig), .bunch_now(loc_bunch)
  );

  always_comb begin
    cap_rec.trig  = run_mode ? ext_trig  : loc_trig;
    cap_rec.bunch = run_mode ? ext_bunch : loc_bunch;
    cap_rec.ttype = trig_type;
    cap_rec.spare = spare;
    push    = l1a && !fifo_full;
    ovf_en  = l1a && fifo_full;
    ovf_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_nxt;
  end

  assign overflow = ovf_q;

  evid_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_ns), .push(push), .din(cap_rec), .pop(pop),
    .dout(head), .empty(fifo_empty), .full(fifo_full), .level(fifo_level)
  );

  evid_serializer #(.W(REC_W)) u_ser (
    .clk(clk), .rst_n(rst_ns), .rec_valid(!fifo_empty), .rec(head),
    .pop(pop), .ser_out(ser_out)
  );

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_ns)
    overflow |=> overflow); // R9
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_ns)
    (l1a && fifo_full) |=> overflow); // R9
endmodule

// File: tb/evid_link_tb.sv
module evid_link_tb;
  logic        clk = 1'b0;
  logic        rst_n, run_mode, l1a, ecr, bcr;
  logic [11:0] bc_max, ext_bunch;
  logic [23:0] ext_trig;
  logic [7:0]  trig_type;
  logic [1:0]  spare;
  logic        ser_out, fifo_empty, fifo_full, overflow;
  logic [4:0]  fifo_level;

  int n_cmp = 0, n_bad = 0, cyc = 0, trig_model = 0;
  bit done = 0;

  // frame receiver state
  int          rx_state = 0, rx_bits = 0, rx_start = 0, rx_n = 0, stop_err = 0;
  logic [45:0] rx_sh;
  logic [45:0] rx_rec [64];
  int          rx_cyc [64];

  evid_link u_dut (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .l1a(l1a), .ecr(ecr),
    .bcr(bcr), .bc_max(bc_max), .ext_trig(ext_trig), .ext_bunch(ext_bunch),
    .trig_type(trig_type), .spare(spare), .ser_out(ser_out),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level),
    .overflow(overflow)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      case (rx_state)
        0: if (ser_out) begin rx_state = 1; rx_bits = 0; rx_start = cyc; end
        1: begin
          rx_sh = {rx_sh[44:0], ser_out};
          rx_bits++;
          if (rx_bits == 46) rx_state = 2;
        end
        default: begin
          if (ser_out) stop_err++;
          if (rx_n < 64) begin rx_rec[rx_n] = rx_sh; rx_cyc[rx_n] = rx_start; end
          rx_n++;
          rx_state = 0;
        end
      endcase
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic accept(input bit with_ecr);
    l1a = 1'b1; ecr = with_ecr;
    @(negedge clk);
    l1a = 1'b0; ecr = 1'b0;
    trig_model = with_ecr ? 1 : trig_model + 1;
  endtask

  task automatic wait_rx(input int target);
    int guard = 0;
    while (rx_n < target && guard < 4000) begin @(negedge clk); guard++; end
    chk("R8 frame count", rx_n, target);
  endtask

  task automatic t_reset();
    chk("R1 ser_out", ser_out, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_single();
    int base = rx_n, c0 = cyc, exp_trig = trig_model;
    trig_type = 8'h5A; spare = 2'b01;
    accept(0);
    wait_rx(base + 1);
    chk("R3 start latency", rx_cyc[base], c0 + 2);
    chk("R4 trig number", rx_rec[base][45:22], exp_trig);
    chk("R2 type field", rx_rec[base][9:2], 8'h5A);
    chk("R2 spare field", rx_rec[base][1:0], 2'b01);
    repeat (5) @(negedge clk);
    chk("R2 idle low", ser_out, 0);
    chk("R2 stop bits", stop_err, 0);
  endtask

  task automatic t_burst3();
    int base = rx_n, t0 = trig_model;
    accept(0); accept(0); accept(0);
    chk("R8 level after 3", fifo_level, 2);
    chk("R8 not empty", fifo_empty, 0);
    wait_rx(base + 3);
    for (int i = 0; i < 3; i++) chk("R8 order", rx_rec[base+i][45:22], t0 + i);
    chk("R10 spacing", rx_cyc[base+2] - rx_cyc[base+1], 48);
  endtask

  task automatic t_ecr_same_cycle();
    int base = rx_n;
    accept(1); accept(0);
    wait_rx(base + 2);
    chk("R5 trig with ecr", rx_rec[base][45:22], 0);
    chk("R5 trig after ecr", rx_rec[base+1][45:22], 1);
  endtask

  task automatic t_bunch(input int k);
    int base = rx_n;
    bcr = 1'b1; @(negedge clk); bcr = 1'b0;
    repeat (k - 1) @(negedge clk);
    accept(0);
    wait_rx(base + 1);
    chk("R6 bunch value", rx_rec[base][21:10], (k - 1) % (int'(bc_max) + 1));
  endtask

  task automatic t_run();
    int base = rx_n;
    run_mode = 1'b1; ext_trig = 24'hABCDEF; ext_bunch = 12'h5A5;
    trig_type = 8'h3C; spare = 2'b10;
    accept(0);
    run_mode = 1'b0;
    wait_rx(base + 1);
    chk("R7 run-mode record", rx_rec[base], {24'hABCDEF, 12'h5A5, 8'h3C, 2'b10});
  endtask

  task automatic t_overflow();
    int base = rx_n, t0 = trig_model;
    for (int i = 0; i < 17; i++) accept(0);
    chk("R8 full at 16", fifo_full, 1);
    chk("R9 no overflow yet", overflow, 0);
    accept(0);
    chk("R9 overflow set", overflow, 1);
    chk("R9 level held", fifo_level, 16);
    wait_rx(base + 17);
    for (int i = 0; i < 17; i++) chk("R9 kept order", rx_rec[base+i][45:22], t0 + i);
    chk("R10 spacing", rx_cyc[base+16] - rx_cyc[base+15], 48);
    repeat (120) @(negedge clk);
    chk("R9 dropped record absent", rx_n, base + 17);
    chk("R9 sticky", overflow, 1);
    chk("R8 empty after drain", fifo_empty, 1);
    chk("R2 idle low after drain", ser_out, 0);
    base = rx_n;
    accept(0);
    wait_rx(base + 1);
    chk("R4 drop still counted", rx_rec[base][45:22], t0 + 18);
  endtask

  initial begin
    rst_n = 1'b0; run_mode = 1'b0; l1a = 1'b0; ecr = 1'b0; bcr = 1'b0;
    bc_max = 12'd99; ext_trig = '0; ext_bunch = '0; trig_type = '0; spare = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_burst3();
    t_ecr_same_cycle();
    t_bunch(10);
    t_bunch(150);
    t_bunch(101);
    t_run();
    t_overflow();
    done = 1;
    report();
  end
endmodule